// File: doc/BRIEF.md
# Dual-Path PWM Clock Generator

This block turns a single bus clock into eight per-channel clock-enable ticks that pace the counters of a PWM unit. Every division is done with enables inside the bus-clock domain, and no derived clock is ever gated or generated. There are two independent paths, A and B. On each path a power-of-two prescaler produces a plain tick stream. A programmable scaler then divides that stream by twice its scale value to give the scaled stream of the path.

Channels are hard-wired in pairs to one of the two paths. Each channel has one select bit that picks the scaled stream or the plain stream of its path. Software programs four registers through a write port made of an address, data and a strobe. Writing a scale register restarts that path's scaler, so the new ratio takes effect at once. Each channel output is registered and is high for exactly one bus cycle per tick.

Top module: `pwm_clkgen`

## Requirements
- R1: While rst_ni is low every tick output is 0. Reset clears all registers, which gives prescale code 0, scale 0 and plain selection everywhere, so after reset every channel ticks on every cycle.
- R2: The plain stream of a path ticks once every 2^code bus cycles. The code is a 3-bit exponent held in the prescale register at address 0: path A uses bits [2:0] and path B uses bits [6:4].
- R3: The scaled stream of a path ticks once every 2^code × 2 × S bus cycles. S is the path's scale register: path A at address 1, path B at address 2, 8 bits each.
- R4: A scale register holding 0 acts as S = 256.
- R5: Channels whose index has bit 1 clear (0, 1, 4, 5) use path A. Channels whose index has bit 1 set (2, 3, 6, 7) use path B.
- R6: Bit i of the select register at address 3 picks the scaled stream for channel i when it is 1 and the plain stream when it is 0.
- R7: A write to a scale register restarts that path's scaler. With prescale code 0, the first scaled tick appears on the output after the 2S-th clock edge that follows the write edge, and no scaled tick appears before it.
- R8: Each output tick is high for one bus cycle whenever the channel's period is longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 prescale, 1 scale A, 2 scale B, 3 select |
| wr_data_i | input | 8 | Register write data |
| tick_o | output | 8 | Per-channel single-cycle clock-enable ticks |

## Verification
The bench builds the block with its default parameters: eight channels, 3-bit prescale codes and 8-bit scale registers. It therefore reaches the largest prescale of 128, the wrap of a scale value of 0 to 256, and the 2 MHz-style example of prescale 2 with scale 200. Random configurations keep codes at 3 or below and scales small so that every channel's period can be measured within the cycle budget. Separate directed cases cover the prescale extreme, the scale extreme and the restart after a scale write.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PRESC   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SCALE_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SCALE_B = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CSEL    = 2'd3;
  localparam int PATH_B_LSB = 4;   // bit offset of path B code in prescale register
  localparam int NUM_PATHS  = 2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   mask_w;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // tick when the low 'code' bits of the free-running count are all ones
  always_comb begin
    mask_w = (CNT_W+1)'(1) << code_i;
    mask   = CNT_W'(mask_w - 1'b1);
    tick_o = ((cnt_q & mask) == mask);
  end
endmodule

// File: rtl/pwm_scaler.sv
module pwm_scaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               reload_i,
  output logic               tick_o
);
  localparam int CNT_W = SCALE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sval;
  logic [CNT_W:0]   dbl;
  logic [CNT_W-1:0] lim;

  always_comb begin
    sval = (scale_i == '0) ? (CNT_W'(1) << SCALE_W) : {1'b0, scale_i};
    dbl  = {sval, 1'b0};
    lim  = CNT_W'(dbl - 1'b1);   // divide by 2*S
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (reload_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == lim);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_clkgen_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CODE_W  = 3,
  parameter int SCALE_W = 8,
  parameter int NUM_CH  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [CODE_W-1:0]  code_a_o,
  output logic [CODE_W-1:0]  code_b_o,
  output logic [SCALE_W-1:0] scale_a_o,
  output logic [SCALE_W-1:0] scale_b_o,
  output logic [NUM_CH-1:0]  sel_o,
  output logic               reload_a_o,
  output logic               reload_b_o
);
  logic wr_presc, wr_sa, wr_sb, wr_sel;

  assign wr_presc = wr_en_i && (wr_addr_i == ADDR_PRESC);
  assign wr_sa    = wr_en_i && (wr_addr_i == ADDR_SCALE_A);
  assign wr_sb    = wr_en_i && (wr_addr_i == ADDR_SCALE_B);
  assign wr_sel   = wr_en_i && (wr_addr_i == ADDR_CSEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_a_o  <= '0;
      code_b_o  <= '0;
      scale_a_o <= '0;
      scale_b_o <= '0;
      sel_o     <= '0;
    end else begin
      if (wr_presc) begin
        code_a_o <= wr_data_i[CODE_W-1:0];
        code_b_o <= wr_data_i[PATH_B_LSB +: CODE_W];
      end
      if (wr_sa)  scale_a_o <= wr_data_i[SCALE_W-1:0];
      if (wr_sb)  scale_b_o <= wr_data_i[SCALE_W-1:0];
      if (wr_sel) sel_o     <= wr_data_i[NUM_CH-1:0];
    end
  end

  assign reload_a_o = wr_sa;
  assign reload_b_o = wr_sb;
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
  import pwm_clkgen_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CODE_W  = 3,
  parameter int SCALE_W = 8,
  parameter int NUM_CH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] tick_o
);
  logic [NUM_PATHS-1:0][CODE_W-1:0]  code;
  logic [NUM_PATHS-1:0][SCALE_W-1:0] scale;
  logic [NUM_PATHS-1:0]              reload;
  logic [NUM_PATHS-1:0]              p_tick;
  logic [NUM_PATHS-1:0]              s_tick;
  logic [NUM_CH-1:0]                 sel_q;
  logic [NUM_CH-1:0]                 tick_d;
  logic [NUM_CH-1:0]                 tick_q;

  pwm_regs #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W),
    .SCALE_W(SCALE_W),
    .NUM_CH (NUM_CH)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .code_a_o  (code[0]),
    .code_b_o  (code[1]),
    .scale_a_o (scale[0]),
    .scale_b_o (scale[1]),
    .sel_o     (sel_q),
    .reload_a_o(reload[0]),
    .reload_b_o(reload[1])
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    pwm_prescale #(.CODE_W(CODE_W)) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .code_i(code[p]),
      .tick_o(p_tick[p])
    );
    pwm_scaler #(.SCALE_W(SCALE_W)) u_scl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (p_tick[p]),
      .scale_i (scale[p]),
      .reload_i(reload[p]),
      .tick_o  (s_tick[p])
    );
  end

  // channel index bit 1 picks the path
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int GRP = (i >> 1) & 1;
    assign tick_d[i] = sel_q[i] ? s_tick[GRP] : p_tick[GRP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
  parameter int CODE_W = 3,
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [NUM_CH-1:0] tick_o,
  input logic [NUM_CH-1:0] sel_q,
  input logic [1:0]        p_tick,
  input logic [1:0]        s_tick,
  input logic [CODE_W-1:0] code_a
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_rst_quiet_R1: assert (tick_o == '0);
  end

  assert_presc_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_a == '0) |-> p_tick[0]);

  assert_scaled_subset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tick != 2'b00) |-> ((s_tick & p_tick) == s_tick));

  assert_group_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_q[0] == sel_q[4]) |-> (tick_o[0] == tick_o[4]));

  assert_group_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_q[2] == sel_q[6]) |-> (tick_o[2] == tick_o[6]));

  assert_reload_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1) |=> !s_tick[0]);

  assert_reload_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd2) |=> !s_tick[1]);
endmodule

bind pwm_clkgen pwm_clkgen_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .tick_o   (tick_o),
  .sel_q    (sel_q),
  .p_tick   (p_tick),
  .s_tick   (s_tick),
  .code_a   (code[0])
);

// File: tb/pwm_clkgen_bench.sv
module pwm_clkgen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] tick_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int code_m [2];
  int scale_m[2];
  logic [7:0] sel_m;

  pwm_clkgen u_pwm_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .tick_o   (tick_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<190000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int ch);
    int p = (ch >> 1) & 1;            // R5 grouping
    int pre = 1 << code_m[p];
    int s = (scale_m[p] == 0) ? 256 : scale_m[p];
    return sel_m[ch] ? pre * 2 * s : pre;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0;
    case (a)
      2'd0: begin code_m[0] = int'(d[2:0]); code_m[1] = int'(d[6:4]); end
      2'd1: scale_m[0] = int'(d);
      2'd2: scale_m[1] = int'(d);
      default: sel_m = d;
    endcase
  endtask

  task automatic wait_tick(input int ch);
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o[ch] && n < 70000);
  endtask

  task automatic measure(input int ch, output int per);
    wait_tick(ch);
    wait_tick(ch);   // first interval may span a config change
    per = 0;
    do begin
      @(negedge clk_i);
      per++;
    end while (!tick_o[ch] && per < 70000);
  endtask

  initial begin
    int per;
    int n;
    void'($urandom(32'd1234));
    code_m = '{0, 0}; scale_m = '{0, 0}; sel_m = '0;

    // R1: quiet during reset
    repeat (3) @(negedge clk_i);
    check("R1 reset ticks", int'(tick_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 post-reset every cycle", int'(tick_o), 255);
    @(negedge clk_i);
    check("R1 post-reset every cycle", int'(tick_o), 255);

    // R2: largest prescale on path A, plain
    wr(2'd0, 8'h07);
    measure(0, per);
    check("R2 presc 128 ch0", per, 128);
    measure(3, per);
    check("R2 path B code 0 ch3", per, 1);

    // R3: prescale 2, scale 200 on path B (example ratio)
    wr(2'd0, 8'h10);
    wr(2'd2, 8'd200);
    wr(2'd3, 8'h04);
    measure(2, per);
    check("R3 presc2 scale200 ch2", per, 800);
    measure(6, per);
    check("R6 plain ch6", per, 2);

    // R4: scale 0 means 256, path A code 0
    wr(2'd0, 8'h10);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'h02);
    measure(1, per);
    check("R4 scale0 ch1", per, 512);

    // R7: restart after scale write, path B code 0
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h04);
    wr(2'd2, 8'd5);
    n = 0;
    // sample 1 still reflects the pre-write state
    do begin
      @(negedge clk_i);
      n++;
    end while (!(n >= 2 && tick_o[2]) && n < 2000);
    check("R7 first scaled tick", n, 11);

    // R8: single-cycle pulse
    wait_tick(2);
    @(negedge clk_i);
    check("R8 pulse width", int'(tick_o[2]), 0);

    // random configurations: R2 R3 R5 R6
    for (int it = 0; it < 7; it++) begin
      logic [7:0] d;
      d = {1'b0, 3'($urandom_range(0, 3)), 1'b0, 3'($urandom_range(0, 3))};
      wr(2'd0, d);
      wr(2'd1, 8'($urandom_range(1, 12)));
      wr(2'd2, 8'($urandom_range(1, 12)));
      wr(2'd3, 8'($urandom));
      for (int ch = 0; ch < 8; ch++) begin
        measure(ch, per);
        check(sel_m[ch] ? "R3 R5 R6 scaled period" : "R2 R5 R6 plain period",
              per, exp_period(ch));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule